// File: doc/BRIEF.md
# Table-Indexed Call and Return Sequencer

This block runs a compact subroutine call in which the target is read from a jump table, and it runs the matching return. When a call instruction starts, the sequencer stores the return address (current PC plus 2) and the current status word in two shadow registers kept only for this call form. It then forms the table entry address from a table base register and the 6-bit index carried in the instruction. It reads one halfword from that address through a simple read port that may stall. The new PC is the table base plus that halfword, zero-extended.

The return instruction copies the shadow PC back to the PC and the shadow status word back to the status word. The surrounding pipeline supplies an instruction-start strobe with the 16-bit instruction word, the base register, the current PC and the status word. It takes the result from a one-cycle completion pulse. While a sequence is in progress the block lowers its ready output, and any new request is held off. Instruction words that are neither a call nor a return are ignored.

Top module: `ctab_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `psw_load` and `mem_rd_req` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a rising edge. A word whose bits [15:6] equal 0000001000 is a call, and bits [5:0] are its table index. `mem_rd_req` rises in the cycle after acceptance.
- R3: During a call read, `mem_rd_addr` equals the base sampled at acceptance plus the index zero-extended and shifted left by one. The sum is taken modulo 2^32.
- R4: While `mem_rd_req` is 1 and `mem_rd_ready` is 0, the read request and its address stay unchanged, for any number of wait cycles.
- R5: In the cycle after the edge where `mem_rd_ready` is sampled high, `done` is 1 for exactly one cycle. In that cycle `psw_load` is 0 and `new_pc` equals the sampled base plus `mem_rd_data` zero-extended to 32 bits.
- R6: Accepting a call stores `cur_pc` + 2 in the shadow PC and `cur_psw` in the shadow status word, both sampled at acceptance.
- R7: The word 16'h07E0 is a return. In the cycle after acceptance, `done` and `psw_load` are 1, and `new_pc` and `new_psw` equal the shadow PC and shadow status word. A return leaves the shadows unchanged.
- R8: `req_ready` is 0 from acceptance to the end of the `done` cycle. Requests presented during that time are not accepted and have no effect.
- R9: An accepted word that is neither a call nor a return causes no `done` and no read, and leaves the shadows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction-start strobe |
| req_instr | input | 16 | Instruction word (call or return) |
| req_ready | output | 1 | Sequencer idle and able to accept |
| tbl_base | input | 32 | Table base register |
| cur_pc | input | 32 | PC of the starting instruction |
| cur_psw | input | 32 | Current status word |
| mem_rd_req | output | 1 | Halfword read request |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_ready | input | 1 | Read data valid / read complete |
| mem_rd_data | input | 16 | Halfword read data |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | PC to load when done |
| new_psw | output | 32 | Status word to load when done and psw_load |
| psw_load | output | 1 | Status word restore (return only) |

## Verification
The hardest situation to reach from the ports is a request that arrives while the block is busy. That request must be refused without disturbing the call in flight or the saved shadows. To create it, the bench asserts a return request during a stalled table read and keeps it asserted until the completion cycle. It then checks that the result is still the call target. It also checks that a later return gives back the address saved by that call. Stalls of several cycles and table entries of 0xFFFF, which show whether the offset is zero-extended, come from the vector table.

// File: rtl/ctab_pkg.sv
package ctab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  localparam logic [9:0]  CALL_PREFIX = 10'b0000001000;
  localparam logic [15:0] RET_WORD    = 16'h07E0;
endpackage

// File: rtl/ctab_fsm.sv
module ctab_fsm
  import ctab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_call,
  input  logic start_ret,
  input  logic rd_ready,
  output logic idle,
  output logic rd_req,
  output logic fin,
  output logic ret_q
);
  seq_state_t state_q, state_d;
  logic       ret_d;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    case (state_q)
      ST_IDLE: begin
        if (start_call) begin
          state_d = ST_MEM;
          ret_d   = 1'b0;
        end else if (start_ret) begin
          state_d = ST_FIN;
          ret_d   = 1'b1;
        end
      end
      ST_MEM:  if (rd_ready) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
    end
  end

  assign idle   = (state_q == ST_IDLE);
  assign rd_req = (state_q == ST_MEM);
  assign fin    = (state_q == ST_FIN);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> rd_req);
endmodule

// File: rtl/ctab_shadow.sv
module ctab_shadow #(
  parameter int AW    = 32,
  parameter int PSW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [AW-1:0]    pc_in,
  input  logic [PSW_W-1:0] psw_in,
  output logic [AW-1:0]    sh_pc,
  output logic [PSW_W-1:0] sh_psw
);
  localparam logic [AW-1:0] PC_STEP = AW'(2);

  logic [AW-1:0]    sh_pc_d;
  logic [PSW_W-1:0] sh_psw_d;

  always_comb begin
    sh_pc_d  = sh_pc;
    sh_psw_d = sh_psw;
    if (cap_en) begin
      sh_pc_d  = pc_in + PC_STEP;
      sh_psw_d = psw_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pc  <= '0;
      sh_psw <= '0;
    end else begin
      sh_pc  <= sh_pc_d;
      sh_psw <= sh_psw_d;
    end
  end

  // R9
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(sh_pc) && $stable(sh_psw)));
endmodule

// File: rtl/ctab_path.sv
module ctab_path #(
  parameter int AW    = 32,
  parameter int PSW_W = 32,
  parameter int IDX_W = 6,
  parameter int HW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_acc,
  input  logic             ret_acc,
  input  logic             rd_req,
  input  logic             rd_take,
  input  logic [AW-1:0]    base_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [HW-1:0]    rd_data,
  input  logic [AW-1:0]    sh_pc,
  input  logic [PSW_W-1:0] sh_psw,
  output logic [AW-1:0]    rd_addr,
  output logic [AW-1:0]    tgt_pc,
  output logic [PSW_W-1:0] tgt_psw
);
  localparam int IDX_PAD = AW - IDX_W - 1;
  localparam int HW_PAD  = AW - HW;

  logic [AW-1:0]    base_q, base_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    tgt_pc_d;
  logic [PSW_W-1:0] tgt_psw_d;
  logic [AW-1:0]    idx_off, data_ext;

  assign idx_off  = {{IDX_PAD{1'b0}}, idx_q, 1'b0};
  assign data_ext = {{HW_PAD{1'b0}}, rd_data};
  assign rd_addr  = base_q + idx_off;

  always_comb begin
    base_d    = base_q;
    idx_d     = idx_q;
    tgt_pc_d  = tgt_pc;
    tgt_psw_d = tgt_psw;
    if (call_acc) begin
      base_d = base_in;
      idx_d  = idx_in;
    end
    if (rd_take) begin
      tgt_pc_d = base_q + data_ext;
    end else if (ret_acc) begin
      tgt_pc_d  = sh_pc;
      tgt_psw_d = sh_psw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      idx_q   <= '0;
      tgt_pc  <= '0;
      tgt_psw <= '0;
    end else begin
      base_q  <= base_d;
      idx_q   <= idx_d;
      tgt_pc  <= tgt_pc_d;
      tgt_psw <= tgt_psw_d;
    end
  end

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_take) |=> $stable(rd_addr));
endmodule

// File: rtl/ctab_seq.sv
module ctab_seq
  import ctab_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PSW_W = 32,
  parameter int IDX_W = 6,
  parameter int HW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_instr,
  output logic             req_ready,
  input  logic [AW-1:0]    tbl_base,
  input  logic [AW-1:0]    cur_pc,
  input  logic [PSW_W-1:0] cur_psw,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_ready,
  input  logic [HW-1:0]    mem_rd_data,
  output logic             done,
  output logic [AW-1:0]    new_pc,
  output logic [PSW_W-1:0] new_psw,
  output logic             psw_load
);
  logic             accept, is_call, is_ret, call_acc, ret_acc, rd_take;
  logic             idle, fin, ret_q;
  logic [AW-1:0]    sh_pc;
  logic [PSW_W-1:0] sh_psw;

  assign is_call  = (req_instr[15:6] == CALL_PREFIX);
  assign is_ret   = (req_instr == RET_WORD);
  assign accept   = req_valid && idle;
  assign call_acc = accept && is_call;
  assign ret_acc  = accept && is_ret;
  assign rd_take  = mem_rd_req && mem_rd_ready;

  ctab_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_call (call_acc),
    .start_ret  (ret_acc),
    .rd_ready   (mem_rd_ready),
    .idle       (idle),
    .rd_req     (mem_rd_req),
    .fin        (fin),
    .ret_q      (ret_q)
  );

  ctab_shadow #(.AW(AW), .PSW_W(PSW_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (call_acc),
    .pc_in  (cur_pc),
    .psw_in (cur_psw),
    .sh_pc  (sh_pc),
    .sh_psw (sh_psw)
  );

  ctab_path #(.AW(AW), .PSW_W(PSW_W), .IDX_W(IDX_W), .HW(HW)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_acc (call_acc),
    .ret_acc  (ret_acc),
    .rd_req   (mem_rd_req),
    .rd_take  (rd_take),
    .base_in  (tbl_base),
    .idx_in   (req_instr[IDX_W-1:0]),
    .rd_data  (mem_rd_data),
    .sh_pc    (sh_pc),
    .sh_psw   (sh_psw),
    .rd_addr  (mem_rd_addr),
    .tgt_pc   (new_pc),
    .tgt_psw  (new_psw)
  );

  assign req_ready = idle;
  assign done      = fin;
  assign psw_load  = fin && ret_q;

  // R3
  call_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_call) |=>
      (mem_rd_req && mem_rd_addr ==
        $past(tbl_base) + {{(AW-IDX_W-1){1'b0}}, $past(req_instr[IDX_W-1:0]), 1'b0}));

  // R5
  take_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_ready) |=> (done && !psw_load));

  // R7
  ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_ret) |=>
      (done && psw_load && new_pc == $past(sh_pc) && new_psw == $past(sh_psw)));

  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !is_call && !is_ret) |=> (!done && !mem_rd_req));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || done) |-> !req_ready);
endmodule

// File: tb/ctab_seq_tb.sv
module ctab_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_instr = 16'h0;
  logic        req_ready;
  logic [31:0] tbl_base = 32'h0;
  logic [31:0] cur_pc = 32'h0;
  logic [31:0] cur_psw = 32'h0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [15:0] mem_rd_data = 16'h0;
  logic        done;
  logic [31:0] new_pc;
  logic [31:0] new_psw;
  logic        psw_load;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctab_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
    .req_ready(req_ready), .tbl_base(tbl_base), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data), .done(done), .new_pc(new_pc), .new_psw(new_psw),
    .psw_load(psw_load)
  );

  localparam logic [15:0] RET = 16'h07E0;

  // fields: idx(6) base(32) pc(32) psw(32) data(16) waits(3)
  localparam int NV = 6;
  localparam logic [120:0] VEC [NV] = '{
    {6'd0,  32'h0000_1000, 32'h0000_0200, 32'h0000_00A5, 16'h0040, 3'd0},
    {6'd1,  32'h0001_0000, 32'h0000_3FFE, 32'h8000_0001, 16'h1234, 3'd1},
    {6'd63, 32'h0002_0000, 32'h0000_7000, 32'h0000_0F0F, 16'hFFFF, 3'd3},
    {6'd17, 32'hFFFF_FFF0, 32'hFFFF_FFFE, 32'h1234_5678, 16'h0020, 3'd2},
    {6'd42, 32'h0000_8000, 32'h0123_4566, 32'hDEAD_BEEF, 16'h8000, 3'd5},
    {6'd5,  32'h7FFF_FFFE, 32'h0000_0010, 32'h0000_0000, 16'h0003, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call with stall count; optionally present a return while busy (R8)
  task automatic do_call(input logic [5:0] idx, input logic [31:0] base,
                         input logic [31:0] pc, input logic [31:0] psw,
                         input logic [15:0] data, input int waits, input bit poke);
    logic [31:0] exp_addr;
    exp_addr = base + {25'd0, idx, 1'b0};
    @(negedge clk);
    req_valid = 1'b1; req_instr = {10'b0000001000, idx};
    tbl_base = base; cur_pc = pc; cur_psw = psw;
    @(posedge clk);
    @(negedge clk);
    req_valid = poke; req_instr = poke ? RET : 16'h0;
    tbl_base = ~base; cur_pc = ~pc; cur_psw = ~psw;
    chk(mem_rd_req == 1'b1, "R2 read request", {31'd0, mem_rd_req}, 32'd1);
    chk(mem_rd_addr == exp_addr, "R3 table address", mem_rd_addr, exp_addr);
    chk(req_ready == 1'b0, "R8 busy", {31'd0, req_ready}, 32'd0);
    for (int w = 0; w < waits; w++) begin
      mem_rd_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(mem_rd_req && mem_rd_addr == exp_addr, "R4 held during wait",
          mem_rd_addr, exp_addr);
    end
    mem_rd_ready = 1'b1; mem_rd_data = data;
    @(posedge clk);
    @(negedge clk);
    mem_rd_ready = 1'b0; mem_rd_data = 16'h0;
    chk(done == 1'b1, "R5 done", {31'd0, done}, 32'd1);
    chk(psw_load == 1'b0, "R5 no psw load", {31'd0, psw_load}, 32'd0);
    chk(new_pc == base + {16'd0, data}, "R5 target", new_pc, base + {16'd0, data});
    req_valid = 1'b0; req_instr = 16'h0;
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", {31'd0, done}, 32'd0);
    chk(req_ready == 1'b1, "R8 ready again", {31'd0, req_ready}, 32'd1);
    if (poke) chk(psw_load == 1'b0, "R8 busy request ignored", {31'd0, psw_load}, 32'd0);
  endtask

  task automatic do_ret(input logic [31:0] exp_pc, input logic [31:0] exp_psw);
    @(negedge clk);
    req_valid = 1'b1; req_instr = RET;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_instr = 16'h0;
    chk(done && psw_load, "R7 return done", {30'd0, done, psw_load}, 32'd3);
    chk(new_pc == exp_pc, "R6 R7 return pc", new_pc, exp_pc);
    chk(new_psw == exp_psw, "R6 R7 return psw", new_psw, exp_psw);
    @(posedge clk);
    @(negedge clk);
    chk(!done && !psw_load, "R7 single pulse", {30'd0, done, psw_load}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && !done && !psw_load && !mem_rd_req, "R1 reset state",
        {28'd0, req_ready, done, psw_load, mem_rd_req}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !done && !mem_rd_req, "R1 after release",
        {29'd0, req_ready, done, mem_rd_req}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      logic [120:0] v;
      v = VEC[i];
      do_call(v[120:115], v[114:83], v[82:51], v[50:19], v[18:3], int'(v[2:0]), 1'b0);
      do_ret(v[82:51] + 32'd2, v[50:19]);
    end

    // R8: return presented while a stalled call is in flight
    do_call(6'd9, 32'h0000_4000, 32'h0000_0A00, 32'h0000_0055, 16'h0100, 3, 1'b1);
    do_ret(32'h0000_0A02, 32'h0000_0055);
    // R7: second return leaves shadows as they were
    do_ret(32'h0000_0A02, 32'h0000_0055);

    // R9: an unrelated word is ignored
    @(negedge clk);
    req_valid = 1'b1; req_instr = 16'h0A3C; cur_pc = 32'h5555_0000; cur_psw = 32'h1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_instr = 16'h0;
    chk(!done && !mem_rd_req && req_ready, "R9 other word ignored",
        {29'd0, done, mem_rd_req, req_ready}, 32'h1);
    // R9: prefix mismatch in the lowest prefix bit is also ignored
    @(negedge clk);
    req_valid = 1'b1; req_instr = 16'h0240;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_instr = 16'h0;
    chk(!done && !mem_rd_req, "R9 near-call word ignored",
        {30'd0, done, mem_rd_req}, 32'h0);
    do_ret(32'h0000_0A02, 32'h0000_0055);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule